// File: doc/BRIEF.md
# Variable-Size Block Fetch Sequencer

This controller brings one atomic instruction block into the issue window. A block starts at a line-aligned header address. Its body occupies between one and sixteen 32-byte lines, and each line carries an 8-instruction segment. The sequencer first makes one paired access to the instruction cache. That access returns the header, which gives the body length, together with the first body line. The sequencer then requests the remaining body lines one after another.

Every line travels through the same path. On a hit the line comes back one cycle after its request. On a miss the sequencer sends the same request to the second-level memory port and waits for the refill. Each delivered line goes to the dispatch port under a valid/ready handshake, tagged with its segment index, and the final line carries a last flag.

A flush abandons the block in progress. If a refill is still outstanding at that moment, its late response is swallowed, and no new block is accepted until it has arrived.

Top module: `blk_fetch_seq`

## Requirements
- R1: After a cycle with reset high, start_ready is 1 and out_valid, ic_req_valid and mem_req_valid are all 0.
- R2: A block accepted on start_valid with start_ready produces, on the next cycle, one cache request with ic_req_hdr high to start_addr.
- R3: The low 4 bits of the header line (ic_rsp_hdr_size, or mem_rsp_hdr_size after a header miss) hold the body line count minus one. Exactly that many lines are dispatched.
- R4: Line base+1 is taken from the header response and never requested. Lines base+2 up to base+N are requested in ascending order, one at a time, with ic_req_hdr low, so a block costs exactly N cache requests.
- R5: Dispatched lines carry segment indices 0 to N-1 in order. Line k holds the content of address base+1+k, and out_last is 1 only on segment N-1.
- R6: With every access a hit and out_ready held high, each line takes 3 cycles. The last handshake therefore occurs 3N cycles after the cycle in which the start is driven.
- R7: A cache miss issues exactly one memory request with the same address and header flag. No cache request follows until the refill arrives, and the refill data is then dispatched.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_line, out_seg and out_last keep their values.
- R9: After a flush, out_valid, ic_req_valid and mem_req_valid are 0 on the next cycle. A refill that is outstanding at the flush is discarded, and start_ready stays 0 until it has returned.
- R10: A start_valid presented while a block is in progress (start_ready 0) has no effect on the requests made or on the lines delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Abort the block in progress |
| start_valid | input | 1 | New block requested |
| start_addr | input | 27 | Line address of the block header |
| start_ready | output | 1 | Sequencer idle and able to accept a block |
| ic_req_valid | output | 1 | Cache access request |
| ic_req_addr | output | 27 | Line address of the access |
| ic_req_hdr | output | 1 | Access is the paired header access |
| ic_rsp_valid | input | 1 | Cache response present |
| ic_rsp_hit | input | 1 | Response is a hit |
| ic_rsp_hdr_size | input | 4 | Header size field: body lines minus one |
| ic_rsp_line | input | 256 | Body line content |
| mem_req_valid | output | 1 | Refill request to second-level memory |
| mem_req_addr | output | 27 | Line address to refill |
| mem_req_hdr | output | 1 | Refill is of the header pair |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_hdr_size | input | 4 | Header size field of a header refill |
| mem_rsp_line | input | 256 | Refilled body line |
| out_valid | output | 1 | Dispatch line valid |
| out_ready | input | 1 | Issue window accepts the line |
| out_line | output | 256 | Line content (8 instructions) |
| out_seg | output | 4 | Segment index within the block |
| out_last | output | 1 | Final line of the block |

## Verification
Some properties are checked by assertions on every cycle. These are the header access that follows an accepted start, the hold of a stalled dispatch line, segment stepping after each handshake, the quiet cycle after a last line or a flush, and the memory request that follows a miss with no cache access while it is pending.

Other behaviour only the bench scenarios can show, because it depends on counts and on contents over whole blocks. This covers:
- the number of cache and memory requests per block;
- the exact 3N-cycle timing of all-hit blocks;
- the one-line and sixteen-line extremes;
- length taken from a refilled header;
- a stray start that leaves the running block untouched;
- the stale refill after a flush, which holds start_ready low and is never dispatched into the next block.

// File: rtl/blk_fetch_pkg.sv
package blk_fetch_pkg;

    localparam int LINE_BYTES_D = 32;
    localparam int INSN_BYTES_D = 4;
    localparam int MAX_INSNS_D  = 128;
    localparam int LADDR_W_D    = 27;

    // body lines of the largest block: one line per instruction segment
    function automatic int max_body_lines(input int max_insns, input int line_bytes,
                                          input int insn_bytes);
        return max_insns / (line_bytes / insn_bytes);
    endfunction

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_REQ,
        FS_LOOK,
        FS_MREQ,
        FS_MWAIT,
        FS_SEND
    } fetch_st_e;

    typedef struct packed {
        logic hit_load;
        logic mem_load;
        logic advance;
    } seq_ctl_t;

endpackage

// File: rtl/blk_fetch_track.sv
module blk_fetch_track #(
    parameter int LADDR_W = 27,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_start,
    input  logic [LADDR_W-1:0] start_addr,
    input  logic               set_size,
    input  logic [CNT_W-1:0]   size_m1,
    input  logic               advance,
    output logic [LADDR_W-1:0] req_addr,
    output logic               req_hdr,
    output logic [CNT_W-1:0]   seg,
    output logic               is_last
);

    logic [LADDR_W-1:0] base_q;
    logic [CNT_W-1:0]   lines_m1_q;
    logic               hdr_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            lines_m1_q <= '0;
            hdr_pend_q <= 1'b0;
            seg        <= '0;
        end else if (load_start) begin
            base_q     <= start_addr;
            lines_m1_q <= '0;
            hdr_pend_q <= 1'b1;
            seg        <= '0;
        end else begin
            if (set_size) begin
                lines_m1_q <= size_m1;
                hdr_pend_q <= 1'b0;
            end
            if (advance) begin
                seg <= seg + CNT_W'(1);
            end
        end
    end

    // header pair sits at the base; segment k lives one line past it
    assign req_addr = hdr_pend_q ? base_q : base_q + LADDR_W'(seg) + LADDR_W'(1);
    assign req_hdr  = hdr_pend_q;
    assign is_last  = !hdr_pend_q && (seg == lines_m1_q);

endmodule

// File: rtl/blk_fetch_drain.sv
module blk_fetch_drain (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic mem_req_fire,
    input  logic mem_rsp_valid,
    output logic drain_busy,
    output logic rsp_live
);

    logic outstanding_q;
    logic abandoned_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
            abandoned_q   <= 1'b0;
        end else begin
            if (mem_rsp_valid) begin
                outstanding_q <= 1'b0;
                abandoned_q   <= 1'b0;
            end else if (flush && outstanding_q) begin
                abandoned_q   <= 1'b1;
            end
            if (mem_req_fire) begin
                outstanding_q <= 1'b1;
            end
        end
    end

    assign drain_busy = abandoned_q;
    assign rsp_live   = mem_rsp_valid && !abandoned_q;

endmodule

// File: rtl/blk_fetch_ctrl.sv
module blk_fetch_ctrl
    import blk_fetch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     start_valid,
    input  logic     drain_busy,
    input  logic     ic_rsp_valid,
    input  logic     ic_rsp_hit,
    input  logic     mem_rsp_live,
    input  logic     out_ready,
    input  logic     is_last,
    output logic     start_ready,
    output logic     load_start,
    output logic     ic_req_valid,
    output logic     mem_req_valid,
    output logic     out_valid,
    output seq_ctl_t ctl
);

    fetch_st_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst || flush) state <= FS_IDLE;
        else              state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:  if (start_valid && start_ready) nxt = FS_REQ;
            FS_REQ:   nxt = FS_LOOK;
            FS_LOOK:  if (ic_rsp_valid) nxt = ic_rsp_hit ? FS_SEND : FS_MREQ;
            FS_MREQ:  nxt = FS_MWAIT;
            FS_MWAIT: if (mem_rsp_live) nxt = FS_SEND;
            FS_SEND:  if (out_ready) nxt = is_last ? FS_IDLE : FS_REQ;
            default:  nxt = FS_IDLE;
        endcase
    end

    assign start_ready   = (state == FS_IDLE) && !drain_busy;
    assign load_start    = start_valid && start_ready && !flush;
    assign ic_req_valid  = (state == FS_REQ) && !flush;
    assign mem_req_valid = (state == FS_MREQ) && !flush;
    assign out_valid     = (state == FS_SEND) && !flush;

    assign ctl.hit_load = (state == FS_LOOK) && ic_rsp_valid && ic_rsp_hit && !flush;
    assign ctl.mem_load = (state == FS_MWAIT) && mem_rsp_live && !flush;
    assign ctl.advance  = out_valid && out_ready && !is_last;

    AST_MISS_TO_MEM: assert property (@(posedge clk) disable iff (rst)
        ((state == FS_LOOK) && ic_rsp_valid && !ic_rsp_hit && !flush)
        |=> (mem_req_valid || flush)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (start_ready && !out_valid && !ic_req_valid && !mem_req_valid)); // R1

endmodule

// File: rtl/blk_fetch_seq.sv
module blk_fetch_seq
    import blk_fetch_pkg::*;
#(
    parameter int LINE_BYTES = LINE_BYTES_D,
    parameter int INSN_BYTES = INSN_BYTES_D,
    parameter int MAX_INSNS  = MAX_INSNS_D,
    parameter int LADDR_W    = LADDR_W_D,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int MAX_LINES = max_body_lines(MAX_INSNS, LINE_BYTES, INSN_BYTES),
    localparam int CNT_W     = cnt_bits(MAX_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               start_valid,
    input  logic [LADDR_W-1:0] start_addr,
    output logic               start_ready,
    output logic               ic_req_valid,
    output logic [LADDR_W-1:0] ic_req_addr,
    output logic               ic_req_hdr,
    input  logic               ic_rsp_valid,
    input  logic               ic_rsp_hit,
    input  logic [CNT_W-1:0]   ic_rsp_hdr_size,
    input  logic [LINE_W-1:0]  ic_rsp_line,
    output logic               mem_req_valid,
    output logic [LADDR_W-1:0] mem_req_addr,
    output logic               mem_req_hdr,
    input  logic               mem_rsp_valid,
    input  logic [CNT_W-1:0]   mem_rsp_hdr_size,
    input  logic [LINE_W-1:0]  mem_rsp_line,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LINE_W-1:0]  out_line,
    output logic [CNT_W-1:0]   out_seg,
    output logic               out_last
);

    seq_ctl_t           ctl;
    logic               load_start, drain_busy, rsp_live, is_last;
    logic [LADDR_W-1:0] req_addr;
    logic               req_hdr;
    logic               set_size;
    logic [CNT_W-1:0]   size_m1;

    blk_fetch_ctrl u_ctrl (
        .clk(clk), .rst(rst), .flush(flush),
        .start_valid(start_valid), .drain_busy(drain_busy),
        .ic_rsp_valid(ic_rsp_valid), .ic_rsp_hit(ic_rsp_hit),
        .mem_rsp_live(rsp_live), .out_ready(out_ready), .is_last(is_last),
        .start_ready(start_ready), .load_start(load_start),
        .ic_req_valid(ic_req_valid), .mem_req_valid(mem_req_valid),
        .out_valid(out_valid), .ctl(ctl)
    );

    assign set_size = (ctl.hit_load || ctl.mem_load) && req_hdr;
    assign size_m1  = ctl.hit_load ? ic_rsp_hdr_size : mem_rsp_hdr_size;

    blk_fetch_track #(.LADDR_W(LADDR_W), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst), .load_start(load_start), .start_addr(start_addr),
        .set_size(set_size), .size_m1(size_m1), .advance(ctl.advance),
        .req_addr(req_addr), .req_hdr(req_hdr), .seg(out_seg), .is_last(is_last)
    );

    blk_fetch_drain u_drain (
        .clk(clk), .rst(rst), .flush(flush),
        .mem_req_fire(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
        .drain_busy(drain_busy), .rsp_live(rsp_live)
    );

    always_ff @(posedge clk) begin
        if (rst)               out_line <= '0;
        else if (ctl.hit_load) out_line <= ic_rsp_line;
        else if (ctl.mem_load) out_line <= mem_rsp_line;
    end

    assign ic_req_addr  = req_addr;
    assign ic_req_hdr   = req_hdr;
    assign mem_req_addr = req_addr;
    assign mem_req_hdr  = req_hdr;
    assign out_last     = is_last;

    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_ready && !flush)
        |=> (flush || (ic_req_valid && ic_req_hdr && ic_req_addr == $past(start_addr)))); // R2

    AST_BODY_REQ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last)
        |=> (flush || (ic_req_valid && !ic_req_hdr))); // R4

    AST_SEG_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last)
        |=> (out_seg == $past(out_seg) + CNT_W'(1))); // R5

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready)
        |=> ((out_valid || flush) && $stable(out_line) && $stable(out_seg)
             && $stable(out_last))); // R8

    AST_MISS_NO_CACHE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !ic_req_valid); // R7

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid && !ic_req_valid && !mem_req_valid)); // R9

endmodule

// File: tb/blk_fetch_seq_test.sv
module blk_fetch_seq_test;
    import blk_fetch_pkg::*;

    localparam int LW = LINE_BYTES_D * 8;
    localparam int CW = cnt_bits(max_body_lines(MAX_INSNS_D, LINE_BYTES_D, INSN_BYTES_D));
    localparam int AW = LADDR_W_D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          start_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          start_ready;
    logic          ic_req_valid, ic_req_hdr;
    logic [AW-1:0] ic_req_addr;
    logic          ic_rsp_valid = 1'b0, ic_rsp_hit = 1'b0;
    logic [CW-1:0] ic_rsp_hdr_size = '0;
    logic [LW-1:0] ic_rsp_line = '0;
    logic          mem_req_valid, mem_req_hdr;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [CW-1:0] mem_rsp_hdr_size = '0;
    logic [LW-1:0] mem_rsp_line = '0;
    logic          out_valid, out_last;
    logic          out_ready = 1'b0;
    logic [LW-1:0] out_line;
    logic [CW-1:0] out_seg;

    blk_fetch_seq uut (
        .clk(clk), .rst(rst), .flush(flush),
        .start_valid(start_valid), .start_addr(start_addr), .start_ready(start_ready),
        .ic_req_valid(ic_req_valid), .ic_req_addr(ic_req_addr), .ic_req_hdr(ic_req_hdr),
        .ic_rsp_valid(ic_rsp_valid), .ic_rsp_hit(ic_rsp_hit),
        .ic_rsp_hdr_size(ic_rsp_hdr_size), .ic_rsp_line(ic_rsp_line),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_hdr(mem_req_hdr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_hdr_size(mem_rsp_hdr_size),
        .mem_rsp_line(mem_rsp_line),
        .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
        .out_seg(out_seg), .out_last(out_last)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;

    // reference model state
    int          blk_base = 0, blk_n = 1, mem_lat = 1, rmode = 0;
    bit          miss_hdr = 0;
    logic [15:0] miss_mask = '0;
    int          req_idx = 0, req_cnt = 0, mem_req_cnt = 0, mem_rsp_cnt = 0;
    int          mem_last_addr = 0, hs_cnt = 0, last_hs_cyc = 0, t_start = 0;
    bit          mem_last_hdr = 0, blk_done = 0;
    logic [LW-1:0] exp_line[$];
    int            exp_seg[$];
    bit            exp_last[$];
    bit            cpend = 0, mhdr = 0, prev_wait = 0, prev_last = 0;
    int            caddr = 0, maddr = 0, mcnt = 0;
    logic [LW-1:0] prev_line = '0;
    logic [CW-1:0] prev_seg = '0;

    function automatic logic [LW-1:0] line_of(input int a);
        logic [LW-1:0] r;
        for (int j = 0; j < LW / 32; j++) r[j*32 +: 32] = 32'(a * 64 + j) ^ 32'h3C00_0000;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural cache, memory and dispatch sink, evaluated every cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                cpend = 0; mcnt = 0; prev_wait = 0;
                ic_rsp_valid = 0; mem_rsp_valid = 0; out_ready = 0;
            end else begin
                out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
                if (prev_wait && !flush)
                    chk(out_valid && out_line == prev_line && out_seg == prev_seg &&
                        out_last == prev_last, "R8 stalled line changed",
                        longint'(out_seg), longint'(prev_seg));
                if (out_valid && out_ready) begin
                    if (exp_line.size() == 0) begin
                        chk(0, "R5 unexpected dispatch", longint'(out_seg), -1);
                    end else begin
                        logic [LW-1:0] el;
                        int es;
                        bit elast;
                        el = exp_line.pop_front();
                        es = exp_seg.pop_front();
                        elast = exp_last.pop_front();
                        chk(out_line == el, "R5 line content", longint'(out_line[31:0]),
                            longint'(el[31:0]));
                        chk(int'(out_seg) == es, "R5 segment index", longint'(out_seg), es);
                        chk(out_last == elast, "R3 last flag", longint'(out_last), longint'(elast));
                    end
                    hs_cnt++;
                    last_hs_cyc = cyc;
                    if (out_last) blk_done = 1;
                end
                prev_wait = out_valid && !out_ready;
                prev_line = out_line; prev_seg = out_seg; prev_last = out_last;

                ic_rsp_valid = cpend;
                ic_rsp_hit = 0;
                if (cpend) begin
                    if (caddr == blk_base) begin
                        ic_rsp_hit = !miss_hdr;
                        ic_rsp_line = line_of(caddr + 1);
                    end else begin
                        int k;
                        k = caddr - blk_base - 1;
                        ic_rsp_hit = (k >= 0 && k < 16) ? !miss_mask[k] : 1'b1;
                        ic_rsp_line = line_of(caddr);
                    end
                    ic_rsp_hdr_size = CW'(blk_n - 1);
                end
                cpend = ic_req_valid;
                if (ic_req_valid) begin
                    int ea;
                    caddr = int'(ic_req_addr);
                    ea = (req_idx == 0) ? blk_base : blk_base + 1 + req_idx;
                    if (req_idx == 0)
                        chk(caddr == ea && ic_req_hdr, "R2 header request", caddr, ea);
                    else
                        chk(caddr == ea && !ic_req_hdr, "R4 body request", caddr, ea);
                    req_idx++;
                    req_cnt++;
                end

                mem_rsp_valid = 0;
                if (mcnt == 1) begin
                    mem_rsp_valid = 1;
                    mem_rsp_line = line_of(mhdr ? maddr + 1 : maddr);
                    mem_rsp_hdr_size = CW'(blk_n - 1);
                    mcnt = 0;
                    mem_rsp_cnt++;
                end else if (mcnt > 1) begin
                    mcnt--;
                end
                if (mem_req_valid) begin
                    mcnt = mem_lat;
                    maddr = int'(mem_req_addr);
                    mhdr = mem_req_hdr;
                    mem_last_addr = maddr;
                    mem_last_hdr = mem_req_hdr;
                    mem_req_cnt++;
                end
            end
        end
    end

    task automatic launch(input int base, input int n);
        blk_base = base; blk_n = n; req_idx = 0; req_cnt = 0; mem_req_cnt = 0;
        hs_cnt = 0; blk_done = 0;
        for (int k = 0; k < n; k++) begin
            exp_line.push_back(line_of(base + 1 + k));
            exp_seg.push_back(k);
            exp_last.push_back(k == n - 1);
        end
        @(negedge clk);
        start_valid = 1; start_addr = AW'(base); t_start = cyc;
        @(negedge clk);
        start_valid = 0;
    endtask

    task automatic wait_done(input string tag);
        int lim;
        lim = cyc + 3000;
        while (!blk_done && cyc < lim) @(negedge clk);
        if (!blk_done) chk(0, {tag, " watchdog expired"}, 0, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk(start_ready && !out_valid && !ic_req_valid && !mem_req_valid,
            "R1 reset state", longint'(start_ready), 1);

        // all-hit blocks: 4 lines, 1 line, 16 lines
        launch(100, 4); wait_done("R5 four-line block");
        chk(req_cnt == 4, "R4 request count n=4", req_cnt, 4);
        chk(hs_cnt == 4, "R3 line count n=4", hs_cnt, 4);
        chk(last_hs_cyc - t_start == 12, "R6 hit timing n=4", last_hs_cyc - t_start, 12);

        launch(140, 1); wait_done("R3 one-line block");
        chk(req_cnt == 1, "R4 request count n=1", req_cnt, 1);
        chk(hs_cnt == 1, "R3 line count n=1", hs_cnt, 1);
        chk(last_hs_cyc - t_start == 3, "R6 hit timing n=1", last_hs_cyc - t_start, 3);

        launch(160, 16); wait_done("R3 sixteen-line block");
        chk(req_cnt == 16, "R4 request count n=16", req_cnt, 16);
        chk(hs_cnt == 16, "R3 line count n=16", hs_cnt, 16);
        chk(last_hs_cyc - t_start == 48, "R6 hit timing n=16", last_hs_cyc - t_start, 48);

        // body miss on segment 2
        miss_mask = 16'h0004; mem_lat = 5;
        launch(220, 4); wait_done("R7 body miss");
        chk(mem_req_cnt == 1, "R7 one refill", mem_req_cnt, 1);
        chk(mem_last_addr == 223 && !mem_last_hdr, "R7 refill address", mem_last_addr, 223);
        chk(req_cnt == 4, "R7 no cache retry", req_cnt, 4);
        miss_mask = '0;

        // header miss: length comes from the refilled header
        miss_hdr = 1; mem_lat = 4;
        launch(260, 3); wait_done("R7 header miss");
        chk(mem_req_cnt == 1 && mem_last_hdr, "R7 header refill flag", longint'(mem_last_hdr), 1);
        chk(mem_last_addr == 260, "R7 header refill address", mem_last_addr, 260);
        chk(hs_cnt == 3, "R3 length from refill", hs_cnt, 3);
        miss_hdr = 0;

        // back-pressure from the issue window
        rmode = 1;
        launch(500, 6); wait_done("R8 back-pressure");
        chk(hs_cnt == 6, "R8 line count under stalls", hs_cnt, 6);
        rmode = 0;

        // stray start while busy
        launch(200, 5);
        repeat (4) @(negedge clk);
        chk(!start_ready, "R10 busy not ready", longint'(start_ready), 0);
        start_valid = 1; start_addr = AW'(999);
        @(negedge clk);
        start_valid = 0;
        wait_done("R10 stray start");
        chk(req_cnt == 5 && hs_cnt == 5, "R10 block unaffected", req_cnt, 5);
        repeat (3) @(negedge clk);
        chk(start_ready && !ic_req_valid, "R10 no stray fetch", longint'(ic_req_valid), 0);

        // flush with a refill outstanding
        miss_mask = 16'h0002; mem_lat = 12;
        launch(300, 4);
        begin
            int lim;
            int rsp0;
            lim = cyc + 200;
            while (mem_req_cnt == 0 && cyc < lim) @(negedge clk);
            chk(mem_req_cnt == 1, "R9 miss reached before flush", mem_req_cnt, 1);
            repeat (2) @(negedge clk);
            flush = 1;
            @(negedge clk);
            flush = 0;
            chk(!out_valid && !ic_req_valid && !mem_req_valid, "R9 quiet after flush",
                longint'(out_valid), 0);
            chk(!start_ready, "R9 waits for stale refill", longint'(start_ready), 0);
            exp_line.delete(); exp_seg.delete(); exp_last.delete();
            rsp0 = mem_rsp_cnt;
            lim = cyc + 200;
            while (mem_rsp_cnt == rsp0 && cyc < lim) @(negedge clk);
            @(negedge clk);
            chk(start_ready, "R9 ready after stale refill", longint'(start_ready), 1);
        end
        miss_mask = '0;
        launch(400, 2); wait_done("R9 block after flush");
        chk(hs_cnt == 2, "R9 stale data not dispatched", hs_cnt, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #4000000;
        fails++; tests++;
        $display("FAIL watchdog global timeout actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule